// File: doc/BRIEF.md
# Bus parity generator and checker with one-clock lag

This block produces and verifies the parity bit of a 32-bit multiplexed address/data bus. Every clock it folds the 32 address/data bits and the 4 command/byte-enable bits into one even-parity bit. It registers that bit, so the parity output always describes the bus values of the previous clock. The parity output enable is the agent's bus-drive decision from the previous clock. The same one-clock lag therefore applies to both the parity value and its drive window.

Drive ownership depends on the agent's role and on the phase. As initiator the agent owns parity for address phases and write data phases. As target it owns parity for read data phases. When the agent is the receiver of a phase, it compares the incoming parity bit one clock later against its own registered value and raises a single-cycle error. The phases it receives are a target address phase, a completed write data phase on the target side, and a completed read data phase on the initiator side. The address-phase and data-phase qualifiers are assumed never to be asserted in the same cycle.

Top module: `pci_par_unit`

## Requirements
- R1: `par_o` equals the XOR of all 32 `ad_i` bits and all 4 `cbe_i` bits, so the 36 bits together with `par_o` hold an even number of ones.
- R2: `par_o` in any cycle reflects the `ad_i`/`cbe_i` values of the previous cycle, whether or not the parity is being driven.
- R3: After a cycle with `is_master_i`=1 and `addr_phase_i`=1, `par_oe_o` is 1 in the next cycle. After a target address phase it is 0.
- R4: After a cycle with `data_phase_i`=1 and `write_i`=1, `par_oe_o` is 1 in the next cycle for an initiator (`is_master_i`=1) and 0 for a target.
- R5: After a cycle with `data_phase_i`=1 and `write_i`=0, `par_oe_o` is 1 in the next cycle for a target (`is_master_i`=0) and 0 for an initiator.
- R6: While `rst_n` is 0, `par_oe_o` and `par_err_o` are 0. In the cycle after a reset edge, `par_o` is 0. After a cycle with neither phase qualifier set, `par_oe_o` is 0.
- R7: After a received data phase that completed (`irdy_i`=1 and `trdy_i`=1), `par_err_o` is 1 for that one cycle exactly when `par_i` differs from the registered parity. The received data phases are target writes and initiator reads.
- R8: After an address phase with `is_master_i`=0, the incoming `par_i` is checked in the same way. After an initiator's own address phase, no check takes place.
- R9: A data phase that did not complete, because `irdy_i` or `trdy_i` is 0, causes no check: `par_err_o` stays 0 in the next cycle whatever `par_i` is.
- R10: `par_err_o` and `par_oe_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ad_i | input | 32 | Address/data value on the bus this cycle |
| cbe_i | input | 4 | Command/byte-enable bits as they appear on the bus |
| par_i | input | 1 | Parity bit received from the bus |
| is_master_i | input | 1 | 1 = agent is the initiator of the transaction, 0 = target |
| addr_phase_i | input | 1 | This cycle is an address phase |
| data_phase_i | input | 1 | This cycle is a data phase |
| write_i | input | 1 | Transaction direction, 1 = write |
| irdy_i | input | 1 | Initiator ready (asserted = 1) |
| trdy_i | input | 1 | Target ready (asserted = 1) |
| par_o | output | 1 | Generated parity, one cycle behind the bus |
| par_oe_o | output | 1 | Drive enable for the parity bit |
| par_err_o | output | 1 | One-cycle parity mismatch pulse |

## Verification
Two functions can fall in the same cycle: checking a received phase, and generating parity for a fresh bus value. The check of the previous phase uses the held parity register, while new address/data values are already being folded into it. The bench provokes this by driving a new random bus pattern in every check cycle, together with a `par_i` that is either correct or has one bit flipped. It judges `par_err_o` against parity computed from the older pattern and `par_o` against the newer one in the following cycle. Its reference counts ones per bit and predicts all three outputs on every clock.

// File: rtl/pci_par_pkg.sv
// Shared types for the parity unit.
// Assumes: one agent role per transaction, stable for the whole phase.
package pci_par_pkg;
    typedef enum logic {
        ROLE_TARGET = 1'b0,
        ROLE_INIT   = 1'b1
    } agent_role_e;

    typedef struct packed {
        logic addr;
        logic data;
        logic wr;
        logic irdy;
        logic trdy;
    } phase_info_t;
endpackage

// File: rtl/par_lane_tree.sv
// Folds a data word and its per-lane command/enable bits into one even
// parity bit. Each byte lane is reduced with its own enable bit first, and
// the lane results are then combined.
// Assumes: DATA_W is a whole multiple of BE_W.
module par_lane_tree #(
    parameter int DATA_W = 32,
    parameter int BE_W   = 4
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [BE_W-1:0]   be_i,
    output logic              parity_o
);
    localparam int LANE_W = DATA_W / BE_W;

    logic [BE_W-1:0] lane_par;

    genvar g;
    generate
        for (g = 0; g < BE_W; g++) begin : g_lane
            // Purpose: parity of one lane plus its enable bit.
            always_comb lane_par[g] = (^data_i[g*LANE_W +: LANE_W]) ^ be_i[g];
        end
    endgenerate

    // Purpose: combine lane results into the word parity.
    always_comb parity_o = ^lane_par;
endmodule

// File: rtl/par_owner.sv
// Decides, from role and phase, whether the agent drives the bus this cycle
// (and so owns parity next cycle) and whether it receives a phase whose
// parity must be checked next cycle.
// Assumes: address and data qualifiers are mutually exclusive.
module par_owner
    import pci_par_pkg::*;
(
    input  agent_role_e role_i,
    input  phase_info_t ph_i,
    output logic        drive_o,
    output logic        recv_o
);
    logic is_init;
    logic data_done;

    // Purpose: decode role and completion of a data phase.
    always_comb begin
        is_init   = (role_i == ROLE_INIT);
        data_done = ph_i.data && ph_i.irdy && ph_i.trdy;
    end

    // Purpose: the driver is the initiator for address and writes, target for reads.
    always_comb begin
        drive_o = (ph_i.addr && is_init)
               || (ph_i.data && (is_init == ph_i.wr));
    end

    // Purpose: the receiver checks a target address phase or a completed inbound data phase.
    always_comb begin
        recv_o = (ph_i.addr && !is_init)
              || (data_done && (is_init != ph_i.wr));
    end
endmodule

// File: rtl/pci_par_unit.sv
// Delayed even-parity generator and checker for a 32-bit multiplexed bus.
// The parity register is loaded every clock; drive enable and check request
// are registered alongside it, so all three outputs lag the bus by one clock.
// Assumes: synchronous active-low reset, qualifiers sampled on rising clk.
module pci_par_unit
    import pci_par_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BE_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] ad_i,
    input  logic [BE_W-1:0]   cbe_i,
    input  logic              par_i,
    input  logic              is_master_i,
    input  logic              addr_phase_i,
    input  logic              data_phase_i,
    input  logic              write_i,
    input  logic              irdy_i,
    input  logic              trdy_i,
    output logic              par_o,
    output logic              par_oe_o,
    output logic              par_err_o
);
    phase_info_t ph;
    agent_role_e role;
    logic        par_now;
    logic        drive_now;
    logic        recv_now;
    logic        par_q;
    logic        oe_q;
    logic        chk_q;

    // Purpose: gather phase qualifiers into the shared record.
    always_comb begin
        ph   = '{addr: addr_phase_i, data: data_phase_i, wr: write_i,
                 irdy: irdy_i, trdy: trdy_i};
        role = is_master_i ? ROLE_INIT : ROLE_TARGET;
    end

    par_lane_tree #(.DATA_W(DATA_W), .BE_W(BE_W)) u_tree (
        .data_i   (ad_i),
        .be_i     (cbe_i),
        .parity_o (par_now)
    );

    par_owner u_owner (
        .role_i  (role),
        .ph_i    (ph),
        .drive_o (drive_now),
        .recv_o  (recv_now)
    );

    // Purpose: hold parity, drive window and check request for one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_q <= 1'b0;
            oe_q  <= 1'b0;
            chk_q <= 1'b0;
        end else begin
            par_q <= par_now;
            oe_q  <= drive_now;
            chk_q <= recv_now;
        end
    end

    // Purpose: present outputs; reset forces drive and error low at once.
    always_comb begin
        par_o     = par_q;
        par_oe_o  = oe_q && rst_n;
        par_err_o = chk_q && rst_n && (par_i != par_q);
    end

    AST_PAR_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (par_o == ^{$past(ad_i), $past(cbe_i)})); // R2

    AST_INIT_ADDR_OE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(is_master_i && addr_phase_i)) |-> par_oe_o); // R3

    AST_WR_TGT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!is_master_i && data_phase_i && write_i) |-> !par_oe_o); // R4

    AST_RD_TGT_OE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!is_master_i && data_phase_i && !write_i)) |-> par_oe_o); // R5

    AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        par_err_o |-> $past(recv_now)); // R7

    AST_ERR_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !(par_err_o && par_oe_o)); // R10

    // Purpose: nothing is driven or flagged while reset is held.
    always_comb begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!par_oe_o && !par_err_o); // R6
        end
    end
endmodule

// File: tb/pci_par_unit_test.sv
module pci_par_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ad_i = '0;
    logic [3:0]  cbe_i = '0;
    logic        par_i = 1'b0;
    logic        is_master_i = 1'b0;
    logic        addr_phase_i = 1'b0;
    logic        data_phase_i = 1'b0;
    logic        write_i = 1'b0;
    logic        irdy_i = 1'b0;
    logic        trdy_i = 1'b0;
    logic        par_o, par_oe_o, par_err_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // state remembered from the previous rising edge
    bit p_rst, p_m, p_a, p_d, p_w, p_i, p_t;
    bit [35:0] p_vec;

    pci_par_unit uut (.*);

    always #5 clk = ~clk;

    function automatic bit even_bit(input bit [35:0] v);
        int c = 0;
        for (int k = 0; k < 36; k++) if (v[k]) c++;
        return (c % 2) == 1;
    endfunction

    task automatic cmp(input bit act, input bit exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // drive one cycle at the falling edge, compare before the rising edge, then latch history
    task automatic step(input bit r, input bit m, input bit a, input bit d, input bit w,
                        input bit i, input bit t, input bit inject);
        bit [35:0] v;
        bit e_par, e_oe, e_err, e_chk, own;
        string rq;
        @(negedge clk);
        v = {$urandom(), 4'($urandom())};
        rst_n = r; is_master_i = m; addr_phase_i = a; data_phase_i = d;
        write_i = w; irdy_i = i; trdy_i = t;
        ad_i = v[35:4]; cbe_i = v[3:0];
        e_par = p_rst ? even_bit(p_vec) : 1'b0;
        par_i = e_par ^ inject;
        #4;
        own   = (p_a && p_m) || (p_d && (p_m == p_w));
        e_chk = (p_a && !p_m) || (p_d && p_i && p_t && (p_m != p_w));
        e_oe  = r && p_rst && own;
        e_err = r && p_rst && e_chk && inject;
        if (!r) begin
            cmp(par_oe_o, 1'b0, "R6 oe in reset");
            cmp(par_err_o, 1'b0, "R6 err in reset");
        end else begin
            cmp(par_o, e_par, p_rst ? "R1/R2 parity" : "R6 parity after reset");
            if (!p_rst || !(p_a || p_d)) rq = "R6 idle oe";
            else if (p_a) rq = "R3 addr oe";
            else if (p_w) rq = "R4 write oe";
            else rq = "R5 read oe";
            cmp(par_oe_o, e_oe, rq);
            if (p_a) rq = "R8 addr check";
            else if (p_d && !(p_i && p_t)) rq = "R9 incomplete";
            else rq = "R7 data check";
            cmp(par_err_o, e_err, rq);
            n_cmp++;
            if (par_err_o && par_oe_o) begin
                n_bad++;
                $display("FAIL R10: actual err=1 oe=1 expected not both");
            end
        end
        @(posedge clk);
        p_rst = r; p_m = m; p_a = a; p_d = d; p_w = w; p_i = i; p_t = t; p_vec = v;
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // reset state
        repeat (3) step(0, 1, 1, 0, 0, 0, 0, 1);
        // R3 initiator address then target address (R8 check, both polarities)
        step(1, 1, 1, 0, 0, 0, 0, 0);
        step(1, 0, 1, 0, 0, 0, 0, 0);
        step(1, 0, 1, 0, 0, 0, 0, 1);
        step(1, 1, 1, 0, 0, 0, 0, 1);
        // R4 writes, R5 reads, each role
        step(1, 1, 0, 1, 1, 1, 1, 0);
        step(1, 0, 0, 1, 1, 1, 1, 0);
        step(1, 0, 0, 1, 0, 1, 1, 1);
        step(1, 1, 0, 1, 0, 1, 1, 0);
        // R7 error on received completed phases
        step(1, 1, 0, 1, 0, 1, 1, 1);
        step(1, 0, 0, 1, 1, 1, 1, 1);
        // R9 waits: no check even with wrong parity
        step(1, 1, 0, 1, 0, 1, 0, 1);
        step(1, 0, 0, 1, 1, 0, 1, 1);
        step(1, 0, 0, 0, 0, 0, 0, 1);
        // mid-run reset then recovery
        step(0, 0, 1, 0, 0, 0, 0, 0);
        step(1, 0, 0, 1, 1, 1, 1, 1);
        // random traffic
        for (int n = 0; n < 4000; n++) begin
            int ph = $urandom_range(0, 2);
            step(($urandom_range(0, 99) != 0), 1'($urandom()),
                 ph == 1, ph == 2, 1'($urandom()), 1'($urandom()), 1'($urandom()),
                 1'($urandom()));
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule